// File: doc/BRIEF.md
# Legacy paravirtual device control register block

This block answers memory accesses that land in one device memory window and holds the control registers a guest driver uses for a legacy paravirtual I/O device: the feature words offered and accepted, the queue selection and its ring address and size, the queue doorbell, the driver status byte and the interrupt status byte. Each access carries a byte offset, a size code and, for writes, data. The decoder sorts it into exactly one outcome: a register access, a forwarded device-configuration access, an ignored write with a warning, or a fatal error.

Guest features, queue address and queue select write straight through to the queue backend over a single strobed port and read back from the backend's inputs. The doorbell value is kept locally and announced to the backend as a one-cycle pulse. A kick from the backend raises a level interrupt that stays up until the guest reads the interrupt status byte. Offsets at or above the register span go to a separate device-configuration port with the span subtracted.

The window size is the register span plus the device-configuration size, rounded up to a power of two, and sets the offset width. The unrounded configuration size bounds the forwarded accesses.

Top module: `vio_legacy_regs`

## Requirements
- R1: The register span is 20 bytes. Registers sit at fixed offsets with fixed sizes: 0x00 device features (4 B), 0x04 guest features (4 B), 0x08 queue address (4 B), 0x0C queue size (2 B), 0x0E queue select (2 B), 0x10 queue notify (2 B), 0x12 driver status (1 B), 0x13 interrupt status (1 B). `req_size` codes 0/1/2/3 mean 1/2/4/8 bytes. Read data is right-aligned and zero-extended. A read of device features returns `dev_features`.
- R2: An access below 0x14 that hits no register start, or that uses a size other than the register's own, raises `err_fatal`. It has no effect and returns read data 0. An interrupt status read of the wrong size does not clear the interrupt.
- R3: An access at offset o ≥ 0x14 with (o − 0x14 + bytes) ≤ DEV_CFG_BYTES drives `cfg_valid` in the same cycle, with `cfg_offset` = o − 0x14 and `req_write`, `req_size` and `req_wdata` passed through. A forwarded read returns `cfg_rdata`, sampled in the request cycle.
- R4: The window is the register span plus DEV_CFG_BYTES, rounded up to a power of two (32 bytes for the default of 10), which sets the offset width. An access at or above 0x14 that does not fit inside DEV_CFG_BYTES is fatal and is not forwarded.
- R5: A `kick` pulse sets the interrupt pending flag, and `irq` is high from the next cycle.
- R6: A 1-byte read of interrupt status returns the pending flag in bit 0 and clears it, so `irq` is low from the next cycle. If `kick` arrives in the same cycle, the read still returns the old flag and the interrupt stays pending.
- R7: A 2-byte write to queue notify stores `req_wdata[15:0]`. One cycle later `notify_valid` pulses for one cycle, with `notify_index` showing the stored value. A later read returns it.
- R8: Any write to device features or interrupt status changes nothing and raises `err_warn`. Any write to queue size raises `err_fatal`.
- R9: A correct-size write to guest features, queue address or queue select asserts `be_we` in the same cycle, with `be_sel` 0, 1 or 2 respectively and `be_wdata` = `req_wdata`. Reads of these registers return `be_guest_features`, `be_queue_addr` and `be_queue_sel`. A queue size read returns `be_queue_size`.
- R10: A 1-byte write to driver status stores `req_wdata[7:0]`, drives it on `dev_status` from the next cycle, and reads back.
- R11: After reset the pending flag, `irq`, the stored notify value, the driver status, `rsp_valid`, `notify_valid` and both error flags are all 0.
- R12: Every request yields `rsp_valid` one cycle later, together with its read data and its error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset within the window |
| req_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of that response |
| err_warn | output | 1 | Ignored write, with the response |
| err_fatal | output | 1 | Illegal access, with the response |
| cfg_valid | output | 1 | Forwarded device-configuration access |
| cfg_write | output | 1 | Direction of the forwarded access |
| cfg_offset | output | ADDR_W | Offset relative to the configuration region |
| cfg_size | output | 2 | Size code of the forwarded access |
| cfg_wdata | output | 32 | Write data of the forwarded access |
| cfg_rdata | input | 32 | Read data from the configuration region |
| dev_features | input | 32 | Features offered by the device |
| be_we | output | 1 | Write strobe to the queue backend |
| be_sel | output | 2 | 0 guest features, 1 queue address, 2 queue select |
| be_wdata | output | 32 | Backend write data |
| be_guest_features | input | 32 | Accepted feature word held by the backend |
| be_queue_addr | input | 32 | Ring address of the selected queue |
| be_queue_sel | input | 16 | Currently selected queue |
| be_queue_size | input | 16 | Size of the selected queue |
| notify_valid | output | 1 | One-cycle doorbell pulse |
| notify_index | output | 16 | Last written queue notify value |
| dev_status | output | 8 | Driver status byte |
| kick | input | 1 | Backend request to interrupt the guest |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the edges of the decode. It covers every offset in the window at every size code, in both directions, before and after the writes have landed. That exposes a decoder that accepts a misaligned or wrongly sized access, forwards a configuration access that runs past the unrounded configuration size, or puts the wrong base on `cfg_offset`. The interrupt is exercised with a wrong-size status read while pending, which a careless design would treat as clearing, and with a kick arriving together with a status read, where a design that lets the read win would drop an interrupt. Readbacks of the doorbell and the status byte catch a store that loses bits or never happens.

// File: rtl/vio_regs_pkg.sv
package vio_regs_pkg;

  localparam int unsigned CFG_BASE = 20;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_DEV_FEAT,
    RG_GST_FEAT,
    RG_Q_ADDR,
    RG_Q_SIZE,
    RG_Q_SEL,
    RG_Q_NOTIFY,
    RG_STATUS,
    RG_ISR
  } vio_reg_e;

  localparam logic [1:0] BE_GUEST = 2'd0;
  localparam logic [1:0] BE_QADDR = 2'd1;
  localparam logic [1:0] BE_QSEL  = 2'd2;

  function automatic int unsigned size_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p << 1;
    return p;
  endfunction

  function automatic int unsigned window_bytes(input int unsigned cfg_bytes);
    return pow2_ceil(CFG_BASE + cfg_bytes);
  endfunction

  function automatic vio_reg_e reg_at(input logic [4:0] off);
    case (off)
      5'd0:    return RG_DEV_FEAT;
      5'd4:    return RG_GST_FEAT;
      5'd8:    return RG_Q_ADDR;
      5'd12:   return RG_Q_SIZE;
      5'd14:   return RG_Q_SEL;
      5'd16:   return RG_Q_NOTIFY;
      5'd18:   return RG_STATUS;
      5'd19:   return RG_ISR;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic logic [1:0] reg_size_code(input vio_reg_e r);
    case (r)
      RG_DEV_FEAT, RG_GST_FEAT, RG_Q_ADDR: return 2'd2;
      RG_Q_SIZE, RG_Q_SEL, RG_Q_NOTIFY:    return 2'd1;
      RG_STATUS, RG_ISR:                   return 2'd0;
      default:                             return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/vio_reg_decode.sv
module vio_reg_decode
  import vio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DEV_CFG_BYTES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_size,
  output vio_reg_e          dec_reg,
  output logic              dec_ok,
  output logic              dec_cfg_hit,
  output logic              dec_warn,
  output logic              dec_fatal
);

  localparam int unsigned CFG_END = CFG_BASE + DEV_CFG_BYTES;

  logic        in_regs;
  logic        cfg_fit;
  logic        width_ok;
  int unsigned span_end;

  always_comb begin
    in_regs     = (32'(req_offset) < CFG_BASE);
    span_end    = 32'(req_offset) + size_bytes(req_size);
    cfg_fit     = !in_regs && (span_end <= CFG_END);
    dec_reg     = in_regs ? reg_at(5'(req_offset)) : RG_NONE;
    width_ok    = (req_size == reg_size_code(dec_reg));
    dec_ok      = 1'b0;
    dec_cfg_hit = 1'b0;
    dec_warn    = 1'b0;
    dec_fatal   = 1'b0;
    if (req_valid) begin
      if (!in_regs) begin
        dec_cfg_hit = cfg_fit;
        dec_fatal   = !cfg_fit;
      end else if (dec_reg == RG_NONE) begin
        dec_fatal = 1'b1;
      end else if (req_write && (dec_reg == RG_DEV_FEAT || dec_reg == RG_ISR)) begin
        dec_warn = 1'b1;
      end else if (req_write && dec_reg == RG_Q_SIZE) begin
        dec_fatal = 1'b1;
      end else if (width_ok) begin
        dec_ok = 1'b1;
      end else begin
        dec_fatal = 1'b1;
      end
    end
  end

  AST_DEC_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({dec_ok, dec_cfg_hit, dec_warn, dec_fatal}) == 1); // R2
  AST_DEC_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(dec_ok || dec_cfg_hit || dec_warn || dec_fatal)); // R12

endmodule

// File: rtl/vio_irq_unit.sv
module vio_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic isr_rd,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (kick)   pending <= 1'b1;
    else if (isr_rd) pending <= 1'b0;
  end

  AST_KICK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> pending); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !kick) |=> !pending); // R6
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!isr_rd && !kick) |=> $stable(pending)); // R6

endmodule

// File: rtl/vio_notify_unit.sv
module vio_notify_unit #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] stored,
  output logic             pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= wr;
      if (wr) stored <= wdata;
    end
  end

  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pulse && stored == $past(wdata))); // R7
  AST_NOTIFY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (!pulse && $stable(stored))); // R7

endmodule

// File: rtl/vio_legacy_regs.sv
module vio_legacy_regs
  import vio_regs_pkg::*;
#(
  parameter  int unsigned DEV_CFG_BYTES = 10,
  localparam int unsigned WINDOW_BYTES  = window_bytes(DEV_CFG_BYTES),
  localparam int unsigned ADDR_W        = $clog2(WINDOW_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              err_warn,
  output logic              err_fatal,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [ADDR_W-1:0] cfg_offset,
  output logic [1:0]        cfg_size,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  input  logic [31:0]       dev_features,
  output logic              be_we,
  output logic [1:0]        be_sel,
  output logic [31:0]       be_wdata,
  input  logic [31:0]       be_guest_features,
  input  logic [31:0]       be_queue_addr,
  input  logic [15:0]       be_queue_sel,
  input  logic [15:0]       be_queue_size,
  output logic              notify_valid,
  output logic [15:0]       notify_index,
  output logic [7:0]        dev_status,
  input  logic              kick,
  output logic              irq
);

  vio_reg_e    dec_reg;
  logic        dec_ok, dec_cfg_hit, dec_warn, dec_fatal;
  logic        isr_rd, nt_wr, st_wr;
  logic        pending;
  logic [31:0] rd_word;

  vio_reg_decode #(
    .ADDR_W        (ADDR_W),
    .DEV_CFG_BYTES (DEV_CFG_BYTES)
  ) i_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_offset  (req_offset),
    .req_size    (req_size),
    .dec_reg     (dec_reg),
    .dec_ok      (dec_ok),
    .dec_cfg_hit (dec_cfg_hit),
    .dec_warn    (dec_warn),
    .dec_fatal   (dec_fatal)
  );

  assign isr_rd = dec_ok && !req_write && (dec_reg == RG_ISR);
  assign nt_wr  = dec_ok &&  req_write && (dec_reg == RG_Q_NOTIFY);
  assign st_wr  = dec_ok &&  req_write && (dec_reg == RG_STATUS);

  vio_irq_unit i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .isr_rd  (isr_rd),
    .pending (pending)
  );
  assign irq = pending;

  vio_notify_unit #(.IDX_W(16)) i_notify (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (nt_wr),
    .wdata  (req_wdata[15:0]),
    .stored (notify_index),
    .pulse  (notify_valid)
  );

  // Device-configuration forwarding, same cycle as the request
  assign cfg_valid  = dec_cfg_hit;
  assign cfg_write  = req_write;
  assign cfg_offset = req_offset - ADDR_W'(CFG_BASE);
  assign cfg_size   = req_size;
  assign cfg_wdata  = req_wdata;

  // Backend write-through
  always_comb begin
    be_we    = 1'b0;
    be_sel   = BE_GUEST;
    be_wdata = req_wdata;
    if (dec_ok && req_write) begin
      case (dec_reg)
        RG_GST_FEAT: begin be_we = 1'b1; be_sel = BE_GUEST; end
        RG_Q_ADDR:   begin be_we = 1'b1; be_sel = BE_QADDR; end
        RG_Q_SEL:    begin be_we = 1'b1; be_sel = BE_QSEL;  end
        default:     be_we = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (dec_reg)
      RG_DEV_FEAT: rd_word = dev_features;
      RG_GST_FEAT: rd_word = be_guest_features;
      RG_Q_ADDR:   rd_word = be_queue_addr;
      RG_Q_SIZE:   rd_word = {16'h0, be_queue_size};
      RG_Q_SEL:    rd_word = {16'h0, be_queue_sel};
      RG_Q_NOTIFY: rd_word = {16'h0, notify_index};
      RG_STATUS:   rd_word = {24'h0, dev_status};
      RG_ISR:      rd_word = {31'h0, pending};
      default:     rd_word = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 32'h0;
      err_warn   <= 1'b0;
      err_fatal  <= 1'b0;
      dev_status <= 8'h0;
    end else begin
      rsp_valid <= req_valid;
      err_warn  <= dec_warn;
      err_fatal <= dec_fatal;
      if (!req_write && dec_ok)           rsp_rdata <= rd_word;
      else if (!req_write && dec_cfg_hit) rsp_rdata <= cfg_rdata;
      else                                rsp_rdata <= 32'h0;
      if (st_wr) dev_status <= req_wdata[7:0];
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_warn && err_fatal)); // R8
  AST_CFG_NOT_BACKEND: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (!be_we && !nt_wr && !st_wr)); // R3
  AST_STATUS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> dev_status == $past(req_wdata[7:0])); // R10
  AST_FATAL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> rsp_rdata == 32'h0); // R2

endmodule

// File: tb/test_vio_legacy_regs.sv
`timescale 1ns/1ps
module test_vio_legacy_regs;

  localparam int AW = 5;
  localparam logic [31:0] DEVF  = 32'hA5A5_0F0F;
  localparam logic [31:0] GSTF  = 32'h1234_5678;
  localparam logic [31:0] QADR  = 32'h0BAD_F00D;
  localparam logic [15:0] QSEL  = 16'h0003;
  localparam logic [15:0] QSIZ  = 16'h0100;
  localparam logic [31:0] CFGRD = 32'hCAFE_D00D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_offset = '0;
  logic [1:0] req_size = 2'd0;
  logic [31:0] req_wdata = 32'h0;
  logic kick = 1'b0;
  logic rsp_valid, err_warn, err_fatal, cfg_valid, cfg_write, be_we, notify_valid, irq;
  logic [31:0] rsp_rdata, cfg_wdata, be_wdata;
  logic [AW-1:0] cfg_offset;
  logic [1:0] cfg_size, be_sel;
  logic [15:0] notify_index;
  logic [7:0] dev_status;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_notify = 16'h0;
  logic [7:0]  m_status = 8'h0;
  logic        m_pend = 1'b0;

  always #2.5 clk = ~clk;

  vio_legacy_regs i_vio_legacy_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_warn(err_warn), .err_fatal(err_fatal),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_offset(cfg_offset), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rdata(CFGRD), .dev_features(DEVF),
    .be_we(be_we), .be_sel(be_sel), .be_wdata(be_wdata),
    .be_guest_features(GSTF), .be_queue_addr(QADR), .be_queue_sel(QSEL), .be_queue_size(QSIZ),
    .notify_valid(notify_valid), .notify_index(notify_index), .dev_status(dev_status),
    .kick(kick), .irq(irq)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One access with an optional simultaneous kick; expectations from the register map
  task automatic access(input bit w, input int off, input int sz, input logic [31:0] wd, input bit k);
    int bytes, rid, rsz;
    bit ok, e_cfg, e_be, e_warn, e_fatal, e_nv;
    logic [1:0] e_sel;
    logic [31:0] e_rd;
    string tag;
    bytes = 1 << sz;
    ok = 0; e_cfg = 0; e_be = 0; e_warn = 0; e_fatal = 0; e_nv = 0;
    e_sel = 2'd0; e_rd = 32'h0; rid = 0; rsz = 3; tag = "R2";
    case (off)
      0:  begin rid = 1; rsz = 2; end
      4:  begin rid = 2; rsz = 2; end
      8:  begin rid = 3; rsz = 2; end
      12: begin rid = 4; rsz = 1; end
      14: begin rid = 5; rsz = 1; end
      16: begin rid = 6; rsz = 1; end
      18: begin rid = 7; rsz = 0; end
      19: begin rid = 8; rsz = 0; end
      default: rid = 0;
    endcase
    if (off >= 20) begin
      if (off - 20 + bytes <= 10) begin e_cfg = 1; tag = "R3"; if (!w) e_rd = CFGRD; end
      else begin e_fatal = 1; tag = "R4"; end
    end else if (rid == 0) begin
      e_fatal = 1;
    end else if (w && (rid == 1 || rid == 8)) begin
      e_warn = 1; tag = "R8";
    end else if (w && rid == 4) begin
      e_fatal = 1; tag = "R8";
    end else if (sz != rsz) begin
      e_fatal = 1;
    end else begin
      ok = 1;
    end
    if (ok) begin
      case (rid)
        1: begin tag = "R1"; e_rd = DEVF; end
        2: begin tag = "R9"; e_rd = GSTF; e_be = w; e_sel = 2'd0; end
        3: begin tag = "R9"; e_rd = QADR; e_be = w; e_sel = 2'd1; end
        4: begin tag = "R9"; e_rd = {16'h0, QSIZ}; end
        5: begin tag = "R9"; e_rd = {16'h0, QSEL}; e_be = w; e_sel = 2'd2; end
        6: begin tag = "R7"; e_rd = {16'h0, m_notify}; e_nv = w; end
        7: begin tag = "R10"; e_rd = {24'h0, m_status}; end
        default: begin tag = "R6"; e_rd = {31'h0, m_pend}; end
      endcase
      if (w) e_rd = 32'h0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = AW'(off); req_size = 2'(sz);
    req_wdata = wd; kick = k;
    #1;
    check({tag, " comb"},
          {cfg_valid, cfg_valid ? {cfg_write, cfg_offset, cfg_size, cfg_wdata} : 40'h0,
           be_we, be_we ? {be_sel, be_wdata} : 34'h0},
          {e_cfg, e_cfg ? {w, AW'(off - 20), 2'(sz), wd} : 40'h0,
           e_be, e_be ? {e_sel, wd} : 34'h0});
    // model update
    if (ok && w && rid == 6) m_notify = wd[15:0];
    if (ok && w && rid == 7) m_status = wd[7:0];
    if (k) m_pend = 1'b1;
    else if (ok && !w && rid == 8) m_pend = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; kick = 1'b0;
    #1;
    check({tag, " rsp R12"},
          {rsp_valid, err_warn, err_fatal, notify_valid, notify_index, rsp_rdata, dev_status, irq},
          {1'b1, e_warn, e_fatal, e_nv, m_notify, e_rd, m_status, m_pend});
  endtask

  task automatic sweep(input bit w);
    for (int off = 0; off < 32; off++)
      for (int sz = 0; sz < 4; sz++)
        access(w, off, sz, 32'h7700_0040 | (off << 8) | sz, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12: watchdog expired, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    check("R11 reset",
          {rsp_valid, err_warn, err_fatal, notify_valid, notify_index, dev_status, irq},
          {1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0});
    sweep(1'b0);   // reads from reset values (R11, R1, R2, R3, R4, R9)
    sweep(1'b1);   // writes (R7, R8, R9, R10, R2, R3, R4)
    sweep(1'b0);   // readback after writes (R7, R10)
    // explicit notify and status values
    access(1'b1, 16, 1, 32'hFFFF_BEEF, 1'b0);  // R7
    access(1'b0, 16, 1, 32'h0, 1'b0);          // R7
    access(1'b1, 18, 0, 32'h0000_00C3, 1'b0);  // R10
    access(1'b0, 18, 0, 32'h0, 1'b0);          // R10
    // kick with an unrelated access, then clears (R5, R6)
    access(1'b0, 0, 2, 32'h0, 1'b1);           // R5 irq rises
    access(1'b0, 19, 1, 32'h0, 1'b0);          // R2 wrong size, no clear
    access(1'b1, 19, 0, 32'h1, 1'b0);          // R8 write ignored, still pending
    access(1'b0, 19, 0, 32'h0, 1'b0);          // R6 returns 1, clears
    access(1'b0, 19, 0, 32'h0, 1'b0);          // R6 returns 0
    // kick and status read together: kick wins (R6)
    access(1'b0, 19, 0, 32'h0, 1'b1);          // returns 0, becomes pending
    access(1'b0, 19, 0, 32'h0, 1'b1);          // returns 1, stays pending
    access(1'b0, 19, 0, 32'h0, 1'b0);          // returns 1, clears
    access(1'b0, 19, 0, 32'h0, 1'b0);          // returns 0
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule